// File: doc/BRIEF.md
# Clocked DRAM SIMM Access and Refresh Sequencer

This block sits between a minicomputer memory bus and a single-sided fast-page DRAM SIMM. The host raises a one-cycle start pulse with an address, a direction and write data. The block then runs a row strobe, a row-to-column address switch, a column strobe and either an early write or a read. Every phase boundary is a parameterised count of a fixed system clock, so the fixed taps of a delay line become cycle counts. A one-cycle refresh request instead runs a CAS-before-RAS sequence. Refresh and access strobes are merged by a selector before they reach the SIMM pins.

Each stored word holds 16 data bits and one even-parity bit. Parity is generated on writes and checked on reads, and a failing read drops a sticky status flag that only reset restores. A two-bit limit input narrows the decoded space to 8, 16 or 32 MB. Starts above the limit are never acknowledged. A start pulse that arrives while an access is already pending or in its row-strobe phase is ignored.

Top module: `dram_simm_ctrl`

## Requirements
- R1: A start pulse sampled at clock edge G, with the block idle, drives ras_no low from edge G+1 for exactly T_RAS cycles.
- R2: ma_o carries the row part addr[23:12] for the first T_MUX cycles of the row strobe, and the column part addr[11:0] from then until the row strobe ends.
- R3: During an access, cas_no falls T_CAS0 cycles (cas_sel_i=0) or T_CAS1 cycles (cas_sel_i=1) after ras_no falls. It is low only while ras_no is low, and both rise on the same edge.
- R4: A write holds we_no low and dq_oe_o high for the whole row strobe, so the write enable is active before the column strobe falls. A read keeps we_no high and dq_oe_o low.
- R5: The stored word is {parity, data} on dq_o[16:0], where bit 16 is the XOR of data bits 15..0.
- R6: done_o pulses one cycle at edge G+T_RAS+1. For a read, rdata_o holds dq_i[15:0] as sampled in the last row-strobe cycle, and rd_valid_o rises on the same edge. rdata_o does not change while rd_valid_o is high or on the edge where it falls. rd_valid_o falls only when a new in-range start is accepted.
- R7: A read whose 17 bits have odd XOR drives perr_no low from the done edge on. perr_no stays low through later good reads until rst_ni is asserted.
- R8: lim_i=2'b00 accepts only addr[23:22]==0, lim_i=2'b01 accepts only addr[23]==0, and lim_i=2'b1x accepts all addresses. A rejected start produces no row strobe, no done_o and no change to rd_valid_o.
- R9: A refresh request sampled at edge R drives cas_no low from edge R+1 and ras_no low T_LEAD cycles later. ras_no stays low for T_RAS cycles, both rise together, we_no stays high, and done_o stays low.
- R10: A refresh requested during an access starts as soon as that access's precharge ends. An access requested during a refresh waits until the refresh and its precharge end. When both requests arrive on the same edge, the refresh runs first.
- R11: ras_no stays high for at least T_PRE cycles between any two row strobes.
- R12: After reset, ras_no, cas_no, we_no and perr_no are high, and done_o, rd_valid_o and dq_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low; also restores the parity flag |
| go_i | input | 1 | One-cycle start strobe |
| wr_i | input | 1 | 1 = write, 0 = read, sampled with go_i |
| addr_i | input | ADDR_W | Word address, sampled with go_i |
| wdata_i | input | 16 | Write data, sampled with go_i |
| lim_i | input | 2 | Address-space limit select |
| cas_sel_i | input | 1 | Picks the short or the long row-to-column strobe delay |
| ref_req_i | input | 1 | One-cycle refresh request |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rd_valid_o | output | 1 | Read data valid; the host samples on its falling edge |
| rdata_o | output | 16 | Read data |
| perr_no | output | 1 | Sticky parity error, active low |
| ras_no | output | 1 | Row strobe to the SIMM, active low |
| cas_no | output | 1 | Column strobe to the SIMM, active low |
| we_no | output | 1 | Write enable to the SIMM, active low |
| ma_o | output | MA_W | Multiplexed row/column address |
| dq_o | output | 17 | Write word: parity and data |
| dq_oe_o | output | 1 | Data drive enable toward the SIMM |
| dq_i | input | 17 | Read word from the SIMM |

## Verification
Counting from the edge that samples the start pulse, the row strobe is due one edge later. The address switch comes T_MUX edges after that, the column strobe T_CAS0 or T_CAS1 edges after that, and done, read data and the parity flag all land on edge T_RAS+1. The bench drives inputs 1 ns after an edge and samples 1 ns after each following edge. It compares every sample against a per-cycle window computed from those counts, so an off-by-one in any phase shows up as a mismatch. Refresh and stall checks use the same counts: a refresh starts T_PRE edges after done, and a start that waits behind a refresh completes T_LEAD+2*T_RAS+T_PRE edges after the refresh began.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
  parameter int unsigned DW = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_REF  = 2'd2,
    ST_PRE  = 2'd3
  } seq_st_e;

  // even parity: stored word XORs to zero
  function automatic logic [DW:0] make_word(input logic [DW-1:0] d);
    return {^d, d};
  endfunction

  function automatic logic word_bad(input logic [DW:0] w);
    return ^w;
  endfunction

  // hi = two top address bits; lim: 00 lowest quarter, 01 lower half, 1x all
  function automatic logic in_window(input logic [1:0] hi, input logic [1:0] lim);
    return lim[1] || (lim[0] ? !hi[1] : (hi == 2'b00));
  endfunction
endpackage

// File: rtl/dsc_seq.sv
`timescale 1ns/1ps
module dsc_seq
  import dsc_pkg::*;
#(
  parameter int unsigned T_MUX  = 6,
  parameter int unsigned T_CAS0 = 10,
  parameter int unsigned T_CAS1 = 12,
  parameter int unsigned T_RAS  = 18,
  parameter int unsigned T_PRE  = 8,
  parameter int unsigned T_LEAD = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    acc_pend_i,
  input  logic    ref_pend_i,
  input  logic    cas_sel_i,
  output seq_st_e st_o,
  output logic    acc_start_o,
  output logic    ref_start_o,
  output logic    acc_ras_o,
  output logic    acc_cas_o,
  output logic    mux_col_o,
  output logic    ref_ras_o,
  output logic    ref_cas_o,
  output logic    last_acc_o
);
  localparam int unsigned CNT_W = $clog2(T_LEAD + T_RAS + T_PRE + 1);
  localparam logic [CNT_W-1:0] C_MUX     = CNT_W'(T_MUX);
  localparam logic [CNT_W-1:0] C_CAS0    = CNT_W'(T_CAS0);
  localparam logic [CNT_W-1:0] C_CAS1    = CNT_W'(T_CAS1);
  localparam logic [CNT_W-1:0] C_LEAD    = CNT_W'(T_LEAD);
  localparam logic [CNT_W-1:0] C_RAS_END = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] C_REF_END = CNT_W'(T_LEAD + T_RAS - 1);
  localparam logic [CNT_W-1:0] C_PRE_END = CNT_W'(T_PRE - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             free;
  logic [CNT_W-1:0] cas_at;

  assign free        = (st_q == ST_IDLE) || (st_q == ST_PRE && cnt_q == C_PRE_END);
  assign ref_start_o = free && ref_pend_i;
  assign acc_start_o = free && !ref_pend_i && acc_pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        ST_ACC: if (cnt_q == C_RAS_END) begin st_q <= ST_PRE; cnt_q <= '0; end
        ST_REF: if (cnt_q == C_REF_END) begin st_q <= ST_PRE; cnt_q <= '0; end
        default: begin
          if (ref_start_o)      begin st_q <= ST_REF;  cnt_q <= '0; end
          else if (acc_start_o) begin st_q <= ST_ACC;  cnt_q <= '0; end
          else if (free)        begin st_q <= ST_IDLE; cnt_q <= '0; end
        end
      endcase
    end
  end

  assign cas_at     = cas_sel_i ? C_CAS1 : C_CAS0;
  assign acc_ras_o  = (st_q == ST_ACC);
  assign acc_cas_o  = acc_ras_o && (cnt_q >= cas_at);
  assign mux_col_o  = acc_ras_o && (cnt_q >= C_MUX);
  assign last_acc_o = acc_ras_o && (cnt_q == C_RAS_END);
  assign ref_cas_o  = (st_q == ST_REF);
  assign ref_ras_o  = ref_cas_o && (cnt_q >= C_LEAD);
  assign st_o       = st_q;
endmodule

// File: rtl/dsc_strobe_mux.sv
`timescale 1ns/1ps
module dsc_strobe_mux (
  input  logic in_ref_i,
  input  logic acc_ras_i,
  input  logic acc_cas_i,
  input  logic acc_wr_i,
  input  logic ref_ras_i,
  input  logic ref_cas_i,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);
  always_comb begin
    if (in_ref_i) begin
      ras_no = !ref_ras_i;
      cas_no = !ref_cas_i;
      we_no  = 1'b1;
    end else begin
      ras_no = !acc_ras_i;
      cas_no = !(acc_cas_i && acc_ras_i);   // column strobe gated by row strobe
      we_no  = !(acc_ras_i && acc_wr_i);    // early write: enabled from first row cycle
    end
  end
endmodule

// File: rtl/dsc_parity_mon.sv
`timescale 1ns/1ps
module dsc_parity_mon
  import dsc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        chk_en_i,
  input  logic [DW:0] word_i,
  output logic        perr_no
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ok_q <= 1'b1;
    else if (chk_en_i && word_bad(word_i))  ok_q <= 1'b0;
  end

  assign perr_no = ok_q;
endmodule

// File: rtl/dram_simm_ctrl.sv
`timescale 1ns/1ps
module dram_simm_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned COL_W  = 12,
  parameter int unsigned T_MUX  = 6,
  parameter int unsigned T_CAS0 = 10,
  parameter int unsigned T_CAS1 = 12,
  parameter int unsigned T_RAS  = 18,
  parameter int unsigned T_PRE  = 8,
  parameter int unsigned T_LEAD = 2,
  localparam int unsigned ROW_W = ADDR_W - COL_W,
  localparam int unsigned MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [1:0]        lim_i,
  input  logic              cas_sel_i,
  input  logic              ref_req_i,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              perr_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [MA_W-1:0]   ma_o,
  output logic [DW:0]       dq_o,
  output logic              dq_oe_o,
  input  logic [DW:0]       dq_i
);
  logic              acc_pend_q, ref_pend_q, req_wr_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DW-1:0]     req_wdata_q;

  seq_st_e st;
  logic acc_start, ref_start, acc_ras, acc_cas, mux_col, ref_ras, ref_cas, last_acc;
  logic in_ref, go_ok, rd_cap;
  logic [MA_W-1:0] row_ma, col_ma;

  // named internal events
  assign in_ref = (st == ST_REF);
  assign go_ok  = go_i && !acc_pend_q && (st != ST_ACC) &&
                  in_window(addr_i[ADDR_W-1 -: 2], lim_i);
  assign rd_cap = last_acc && !req_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_pend_q  <= 1'b0;
      ref_pend_q  <= 1'b0;
      req_wr_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      done_o      <= 1'b0;
      rd_valid_o  <= 1'b0;
      rdata_o     <= '0;
    end else begin
      ref_pend_q <= ref_req_i || (ref_pend_q && !ref_start);
      if (go_ok) begin
        acc_pend_q  <= 1'b1;
        req_wr_q    <= wr_i;
        req_addr_q  <= addr_i;
        req_wdata_q <= wdata_i;
      end else if (acc_start) begin
        acc_pend_q  <= 1'b0;
      end
      done_o <= last_acc;
      if (rd_cap) begin
        rdata_o    <= dq_i[DW-1:0];
        rd_valid_o <= 1'b1;
      end else if (go_ok) begin
        rd_valid_o <= 1'b0;
      end
    end
  end

  dsc_seq #(
    .T_MUX(T_MUX), .T_CAS0(T_CAS0), .T_CAS1(T_CAS1),
    .T_RAS(T_RAS), .T_PRE(T_PRE), .T_LEAD(T_LEAD)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_pend_i  (acc_pend_q),
    .ref_pend_i  (ref_pend_q),
    .cas_sel_i   (cas_sel_i),
    .st_o        (st),
    .acc_start_o (acc_start),
    .ref_start_o (ref_start),
    .acc_ras_o   (acc_ras),
    .acc_cas_o   (acc_cas),
    .mux_col_o   (mux_col),
    .ref_ras_o   (ref_ras),
    .ref_cas_o   (ref_cas),
    .last_acc_o  (last_acc)
  );

  dsc_strobe_mux u_mux (
    .in_ref_i  (in_ref),
    .acc_ras_i (acc_ras),
    .acc_cas_i (acc_cas),
    .acc_wr_i  (req_wr_q),
    .ref_ras_i (ref_ras),
    .ref_cas_i (ref_cas),
    .ras_no    (ras_no),
    .cas_no    (cas_no),
    .we_no     (we_no)
  );

  dsc_parity_mon u_par (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chk_en_i (rd_cap),
    .word_i   (dq_i),
    .perr_no  (perr_no)
  );

  assign row_ma  = MA_W'(req_addr_q[ADDR_W-1:COL_W]);
  assign col_ma  = MA_W'(req_addr_q[COL_W-1:0]);
  assign ma_o    = mux_col ? col_ma : row_ma;
  assign dq_o    = make_word(req_wdata_q);
  assign dq_oe_o = acc_ras && req_wr_q;
endmodule

// File: rtl/dsc_chk.sv
`timescale 1ns/1ps
module dsc_chk
  import dsc_pkg::*;
#(
  parameter int unsigned T_PRE = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_no,
  input logic          cas_no,
  input logic          we_no,
  input logic          in_ref,
  input logic          rd_valid_o,
  input logic [DW-1:0] rdata_o,
  input logic          perr_no
);
  localparam int unsigned HW = $clog2(T_PRE + 1) + 1;
  localparam logic [HW-1:0] H_MIN = HW'(T_PRE);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hi_cnt <= H_MIN;
    else if (!ras_no)                 hi_cnt <= '0;
    else if (hi_cnt < H_MIN)          hi_cnt <= hi_cnt + 1'b1;
  end

  assert_cas_needs_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ref && !cas_no) |-> !ras_no);
  assert_release_together_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> $rose(cas_no));
  assert_we_steady_under_cas_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> $stable(we_no));
  assert_rdata_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> $stable(rdata_o));
  assert_rdata_at_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_valid_o) |-> $stable(rdata_o));
  assert_perr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |=> !perr_no);
  assert_cbr_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ref && !ras_no) |-> (!cas_no && we_no));
  assert_precharge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (hi_cnt >= H_MIN));
endmodule

bind dram_simm_ctrl dsc_chk #(.T_PRE(T_PRE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_no     (ras_no),
  .cas_no     (cas_no),
  .we_no      (we_no),
  .in_ref     (in_ref),
  .rd_valid_o (rd_valid_o),
  .rdata_o    (rdata_o),
  .perr_no    (perr_no)
);

// File: tb/tb_dram_simm_ctrl.sv
`timescale 1ns/1ps
module tb_dram_simm_ctrl;
  localparam int T_MUX = 6, T_CAS0 = 10, T_CAS1 = 12, T_RAS = 18, T_PRE = 8, T_LEAD = 2;
  // {wr, cas_sel, addr[23:0], data/expected[15:0]}
  localparam logic [41:0] VEC [8] = '{
    {1'b1, 1'b0, 24'h001002, 16'hA5C3},
    {1'b1, 1'b1, 24'h123456, 16'h0001},
    {1'b1, 1'b0, 24'hFFFEFD, 16'hFFFF},
    {1'b0, 1'b1, 24'h001002, 16'hA5C3},
    {1'b0, 1'b0, 24'h123456, 16'h0001},
    {1'b1, 1'b1, 24'h7A5C3E, 16'h0000},
    {1'b0, 1'b1, 24'hFFFEFD, 16'hFFFF},
    {1'b0, 1'b0, 24'h7A5C3E, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, wr = 1'b0, cas_sel = 1'b0, ref_req = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  lim = 2'b10;
  logic done, rd_valid, perr_n, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rdata;
  logic [11:0] ma;
  logic [16:0] dq_o, dq_i;

  logic [16:0] mem [256];
  logic [11:0] row_l = '0, col_l = '0;
  int cbr_cnt = 0, n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dram_simm_ctrl #(.T_MUX(T_MUX), .T_CAS0(T_CAS0), .T_CAS1(T_CAS1), .T_RAS(T_RAS),
                   .T_PRE(T_PRE), .T_LEAD(T_LEAD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .lim_i(lim), .cas_sel_i(cas_sel), .ref_req_i(ref_req), .done_o(done),
    .rd_valid_o(rd_valid), .rdata_o(rdata), .perr_no(perr_n), .ras_no(ras_n),
    .cas_no(cas_n), .we_no(we_n), .ma_o(ma), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i));

  // SIMM model: 256 words indexed by low nibbles of row and column
  always @(negedge ras_n) row_l = ma;
  always @(negedge cas_n) begin
    if (!ras_n) begin
      col_l = ma;
      if (!we_n) mem[{row_l[3:0], ma[3:0]}] = dq_o;
    end else cbr_cnt++;
  end
  assign dq_i = (!ras_n && !cas_n && we_n) ? mem[{row_l[3:0], col_l[3:0]}] : 17'h0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic w, input logic cs, input logic [23:0] a, input logic [15:0] d);
    int e_ras = 0, e_cas = 0, e_mux = 0, e_we = 0, done_n = -1;
    int tc = cs ? T_CAS1 : T_CAS0;
    logic [11:0] exp_ma;
    wr = w; cas_sel = cs; addr = a; wdata = d; go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    for (int n = 1; n <= T_RAS + 1; n++) begin
      @(posedge clk); #1;
      if (ras_n !== (n > T_RAS)) e_ras++;
      if (cas_n !== !(n >= tc + 1 && n <= T_RAS)) e_cas++;
      if (n <= T_RAS) begin
        exp_ma = (n >= T_MUX + 1) ? a[11:0] : a[23:12];
        if (ma !== exp_ma) e_mux++;
        if (we_n !== !w || dq_oe !== w) e_we++;
      end
      if (done === 1'b1 && done_n < 0) done_n = n;
    end
    check(e_ras == 0, "R1 row strobe window", e_ras, 0);
    check(e_mux == 0, "R2 row/column switch", e_mux, 0);
    check(e_cas == 0, "R3 column strobe window", e_cas, 0);
    check(e_we == 0, "R4 early write enable", e_we, 0);
    check(done_n == T_RAS + 1, "R6 done cycle", done_n, T_RAS + 1);
    if (w) check(mem[{a[15:12], a[3:0]}] == {^d, d}, "R5 stored word",
                 mem[{a[15:12], a[3:0]}], {^d, d});
    else   check(rd_valid === 1'b1 && rdata === d, "R6 read data", {rd_valid, rdata}, {1'b1, d});
    repeat (T_PRE) @(posedge clk);
    #1;
  endtask

  task automatic reject(input logic [23:0] a, input string tag);
    int errs = 0;
    logic v0 = rd_valid;
    wr = 1'b0; addr = a; go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    for (int n = 1; n <= T_RAS + 2; n++) begin
      @(posedge clk); #1;
      if (ras_n !== 1'b1 || done !== 1'b0) errs++;
    end
    check(errs == 0, tag, errs, 0);
    check(rd_valid === v0, "R8 rd_valid untouched by rejected start", rd_valid, v0);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1 n++;
      if (done === 1'b1) break;
    end
  endtask

  initial begin
    int errs, c0, n, ras_at;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check({ras_n, cas_n, we_n, perr_n} === 4'hF, "R12 strobes high in reset",
          {ras_n, cas_n, we_n, perr_n}, 4'hF);
    check({done, rd_valid, dq_oe} === 3'b000, "R12 status low in reset", {done, rd_valid, dq_oe}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // table walk
    for (int i = 0; i < 8; i++)
      run_access(VEC[i][41], VEC[i][40], VEC[i][39:16], VEC[i][15:0]);
    check(perr_n === 1'b1, "R7 flag set after good reads", perr_n, 1);

    // R8 address limit
    lim = 2'b00;
    reject(24'h400000, "R8 8MB limit rejects");
    run_access(1'b1, 1'b0, 24'h3FF0F1, 16'h1234);
    lim = 2'b01;
    reject(24'h800000, "R8 16MB limit rejects");
    run_access(1'b1, 1'b1, 24'h456072, 16'h8001);
    lim = 2'b10;
    run_access(1'b0, 1'b0, 24'h3FF0F1, 16'h1234);

    // R9 standalone refresh
    c0 = cbr_cnt; errs = 0;
    ref_req = 1'b1; @(posedge clk); #1 ref_req = 1'b0;
    for (int k = 1; k <= T_LEAD + T_RAS + 1; k++) begin
      @(posedge clk); #1;
      if (cas_n !== !(k <= T_LEAD + T_RAS)) errs++;
      if (ras_n !== !(k >= T_LEAD + 1 && k <= T_LEAD + T_RAS)) errs++;
      if (we_n !== 1'b1 || done !== 1'b0) errs++;
    end
    check(errs == 0, "R9 refresh strobe order", errs, 0);
    check(cbr_cnt == c0 + 1, "R9 one CBR event", cbr_cnt, c0 + 1);
    repeat (T_PRE) @(posedge clk);
    #1;

    // R10 refresh requested during an access
    c0 = cbr_cnt; ras_at = -1; n = -1;
    wr = 1'b1; addr = 24'h0AB0CD; wdata = 16'h5A5A; go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    for (int k = 1; k <= T_RAS + 2 * T_PRE + T_LEAD + T_RAS + 2; k++) begin
      @(posedge clk); #1;
      if (k == 2) ref_req = 1'b1;
      if (k == 3) ref_req = 1'b0;
      if (done === 1'b1 && n < 0) n = k;
      if (k > T_RAS + 1 && ras_n === 1'b0 && ras_at < 0) ras_at = k;
    end
    check(n == T_RAS + 1, "R10 access not delayed by refresh", n, T_RAS + 1);
    check(ras_at == T_RAS + 1 + T_PRE + T_LEAD, "R10 refresh after precharge",
          ras_at, T_RAS + 1 + T_PRE + T_LEAD);
    check(cbr_cnt == c0 + 1, "R10 deferred refresh ran", cbr_cnt, c0 + 1);

    // R10 access requested during a refresh
    ref_req = 1'b1; @(posedge clk); #1 ref_req = 1'b0;
    @(posedge clk); #1;
    wr = 1'b1; addr = 24'h0110EE; wdata = 16'h0F0F; go = 1'b1;
    @(posedge clk); #1 go = 1'b0;
    wait_done(n);
    check(n == T_LEAD + 2 * T_RAS + T_PRE - 1, "R10 access stalled by refresh",
          n, T_LEAD + 2 * T_RAS + T_PRE - 1);
    repeat (T_PRE) @(posedge clk);
    #1;

    // R10 tie: refresh first
    ref_req = 1'b1; wr = 1'b0; addr = 24'h0110EE; go = 1'b1;
    @(posedge clk); #1 begin ref_req = 1'b0; go = 1'b0; end
    wait_done(n);
    check(n == 1 + T_LEAD + 2 * T_RAS + T_PRE, "R10 tie refresh wins",
          n, 1 + T_LEAD + 2 * T_RAS + T_PRE);
    check(rdata === 16'h0F0F, "R6 read after stall", rdata, 16'h0F0F);
    repeat (T_PRE) @(posedge clk);
    #1;

    // R7 parity error
    mem[8'h12] = mem[8'h12] ^ 17'h00008;
    run_access(1'b0, 1'b0, 24'h001002, 16'hA5CB);
    check(perr_n === 1'b0, "R7 parity error flagged", perr_n, 0);
    run_access(1'b0, 1'b1, 24'h123456, 16'h0001);
    check(perr_n === 1'b0, "R7 flag sticky over good read", perr_n, 0);
    rst_n = 1'b0; @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(perr_n === 1'b1, "R7 reset restores flag", perr_n, 1);
    check(rd_valid === 1'b0, "R12 rd_valid cleared by reset", rd_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule